// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter

This block is a small up-counter in plain binary in which every change of state happens on the rising clock edge. Four operations are available: clearing to zero, loading a data word, counting up by one and holding. When several control inputs are active together, a fixed priority chooses between them. Clear wins over load, load wins over count, and count wins over hold. Clear and load are active low. Both are sampled at the edge like the other inputs. Nothing in the counter acts asynchronously.

Two count enables must both be high before the counter advances. The first is a parallel enable. The second is a trickle enable, and it also gates the terminal-count output. That output is high only when the count is at its maximum and the trickle enable is high. Counters can therefore be chained into a wider synchronous counter with no extra gates. In a ripple arrangement, each stage's terminal count feeds the trickle enable of the next stage. In a carry-lookahead arrangement, the first stage's terminal count also feeds the parallel enable of every later stage.

The counter has no asynchronous reset. It reaches a defined state when the clear input is held low for at least one rising edge. Terminal count is decoded directly from the registered count and the trickle enable. It is a data signal only, and is not meant to drive a clock or a reset.

Top module: `sync_bin_counter`

## Requirements
- R1: When counting, the value advances by one in plain binary modulo 2^WIDTH (16 at the default WIDTH of 4), and it wraps from the all-ones value to zero.
- R2: The count changes only at a rising clock edge. Changing any input between edges leaves the count output unchanged until the next rising edge.
- R3: If `clr_n` is 0 at a rising edge, the count becomes 0, whatever the values of `load_n`, `en_par`, `en_trk` and `din`.
- R4: If `clr_n` is 1 and `load_n` is 0 at a rising edge, the count takes the value of `din`, whatever the values of the enables.
- R5: If `clr_n` and `load_n` are both 1 at a rising edge, the count increments only when `en_par` and `en_trk` are both 1.
- R6: If `clr_n` and `load_n` are both 1 and either enable is 0 at a rising edge, the count holds its value.
- R7: `term` is 1 exactly when every count bit is 1 and `en_trk` is 1. `en_par`, `load_n` and `clr_n` have no effect on `term`.
- R8: The priority is clear, then load, then count, then hold. This holds for all 16 combinations of {`clr_n`, `load_n`, `en_par`, `en_trk`} from every starting count.
- R9: Three counters wired for carry lookahead form a 12-bit counter that counts correctly through every stage wrap. In this wiring, stage 0 has both enables tied high. Stage 1 takes stage 0's `term` on both of its enables. Stage 2 takes stage 0's `term` on `en_par` and stage 1's `term` on `en_trk`.
- R10: The block has no asynchronous reset. One rising edge with `clr_n` low puts the count at 0 from an unknown state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_par | input | 1 | Parallel count enable |
| en_trk | input | 1 | Trickle count enable; also gates `term` |
| din | input | WIDTH | Data word copied into the counter on load |
| count | output | WIDTH | Registered count value |
| term | output | 1 | Terminal count: count all ones and `en_trk` high |

## Verification
The bench sweeps every starting count against all sixteen control combinations, using two data words. This exposes any priority inversion. For example, a design that let load beat clear would show the data word where zero is expected. A design that counted on only one enable would advance when it should hold. `term` is checked with the parallel enable and load active against it. A decode that used the wrong enable, or missed the trickle gating, would assert at the wrong time. In the 12-bit lookahead chain, the carries only come out right if the enables and terminal counts are gated correctly. A fault there would skip or repeat counts at the 15-to-0 and 255-to-0 rollovers. The bench also changes inputs between edges and checks that the count stays put until the next edge, which would catch any asynchronous clear or load path.

// File: rtl/ctr_pkg.sv
// Package: shared operating-mode type for the synchronous counter.
// Assumes: no other package defines ctr_mode_t.
package ctr_pkg;

    // One operating mode is selected at each rising edge.
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_COUNT = 2'd1,
        MODE_LOAD  = 2'd2,
        MODE_CLEAR = 2'd3
    } ctr_mode_t;

endpackage

// File: rtl/ctr_mode_dec.sv
// Module: ctr_mode_dec
// Decodes the control inputs into a single operating mode using the fixed
// priority clear > load > count > hold.
// Assumes: the controls are sampled synchronously by the state register.
module ctr_mode_dec
    import ctr_pkg::*;
(
    input  logic      clr_n,
    input  logic      load_n,
    input  logic      en_par,
    input  logic      en_trk,
    output ctr_mode_t mode
);

    // Priority encoder over the four controls.
    always_comb begin
        if (!clr_n)
            mode = MODE_CLEAR;
        else if (!load_n)
            mode = MODE_LOAD;
        else if (en_par && en_trk)
            mode = MODE_COUNT;
        else
            mode = MODE_HOLD;
    end

endmodule

// File: rtl/ctr_state_reg.sv
// Module: ctr_state_reg
// Holds the count and applies the selected mode at each rising edge.
// Assumes: there is no asynchronous reset; MODE_CLEAR is the only
// initialisation path. The increment wraps at 2^WIDTH.
module ctr_state_reg
    import ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  ctr_mode_t        mode,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);

    localparam logic [WIDTH-1:0] ZERO = '0;
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

    logic [WIDTH-1:0] q_next;

    // Next-state selection for each mode.
    always_comb begin
        unique case (mode)
            MODE_CLEAR: q_next = ZERO;
            MODE_LOAD:  q_next = din;
            MODE_COUNT: q_next = q + ONE;
            default:    q_next = q;
        endcase
    end

    // Edge-triggered count storage.
    always_ff @(posedge clk) begin
        q <= q_next;
    end

endmodule

// File: rtl/ctr_tc_decode.sv
// Module: ctr_tc_decode
// Combinational terminal-count decode: all count bits set AND trickle enable.
// Assumes: the output is used as data (a cascade enable) only, never as a
// clock or a reset.
module ctr_tc_decode #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] q,
    input  logic             en_trk,
    output logic             term
);

    logic [WIDTH:0] chain;

    assign chain[0] = en_trk;

    // AND chain, one stage per count bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_and
        assign chain[i+1] = chain[i] & q[i];
    end

    assign term = chain[WIDTH];

endmodule

// File: rtl/sync_bin_counter.sv
// Module: sync_bin_counter
// Cascadable synchronous binary up-counter with synchronous clear and load,
// two count enables, and a terminal count gated by the trickle enable.
// Assumes: clr_n is held low for at least one edge before the count is used.
module sync_bin_counter #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             en_par,
    input  logic             en_trk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count,
    output logic             term
);

    ctr_pkg::ctr_mode_t mode;

    ctr_mode_dec u_mode (
        .clr_n (clr_n),
        .load_n(load_n),
        .en_par(en_par),
        .en_trk(en_trk),
        .mode  (mode)
    );

    ctr_state_reg #(.WIDTH(WIDTH)) u_reg (
        .clk (clk),
        .mode(mode),
        .din (din),
        .q   (count)
    );

    ctr_tc_decode #(.WIDTH(WIDTH)) u_tc (
        .q     (count),
        .en_trk(en_trk),
        .term  (term)
    );

endmodule

// File: rtl/sync_bin_counter_chk.sv
// Module: sync_bin_counter_chk
// Property checker bound to every sync_bin_counter instance.
// Assumes: the checks are armed only after the first clear has been sampled,
// because the count is unknown before that.
module sync_bin_counter_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clr_n,
    input logic             load_n,
    input logic             en_par,
    input logic             en_trk,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] count,
    input logic             term
);

    logic armed = 1'b0;

    // Arm the checks once a clear has been applied (R10).
    always_ff @(posedge clk) begin
        if (!clr_n) armed <= 1'b1;
    end

    assert_clear_R3: assert property (@(posedge clk) disable iff (!armed)
        !clr_n |=> (count == '0));

    assert_load_R4: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && !load_n) |=> (count == $past(din)));

    assert_count_R5: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && load_n && en_par && en_trk) |=> (count == WIDTH'($past(count) + 1'b1)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && load_n && !(en_par && en_trk)) |=> $stable(count));

    assert_term_R7: assert property (@(posedge clk) disable iff (!armed)
        term == ((&count) && en_trk));

endmodule

bind sync_bin_counter sync_bin_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk   (clk),
    .clr_n (clr_n),
    .load_n(load_n),
    .en_par(en_par),
    .en_trk(en_trk),
    .din   (din),
    .count (count),
    .term  (term)
);

// File: tb/sync_bin_counter_bench.sv
// Bench: sweeps every start state against every control combination on a
// 4-bit counter, then runs a 3-stage carry-lookahead chain over 12 bits.
module sync_bin_counter_bench;

    logic       clk = 1'b0;
    logic       clr_n = 1'b1, load_n = 1'b1, en_par = 1'b0, en_trk = 1'b0;
    logic [3:0] din = 4'd0;
    logic [3:0] count;
    logic       term;

    int checks = 0;
    int fails  = 0;
    logic [3:0] model;

    always #2 clk = ~clk;   // 250 MHz

    sync_bin_counter #(.WIDTH(4)) u_sync_bin_counter (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
        .en_trk(en_trk), .din(din), .count(count), .term(term)
    );

    // Carry-lookahead chain (R9).
    logic       c_clr_n = 1'b1;
    logic [3:0] q0, q1, q2;
    logic       t0, t1, t2;

    sync_bin_counter #(.WIDTH(4)) u_stg0 (
        .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .en_par(1'b1),
        .en_trk(1'b1), .din(4'd0), .count(q0), .term(t0)
    );
    sync_bin_counter #(.WIDTH(4)) u_stg1 (
        .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .en_par(t0),
        .en_trk(t0), .din(4'd0), .count(q1), .term(t1)
    );
    sync_bin_counter #(.WIDTH(4)) u_stg2 (
        .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .en_par(t0),
        .en_trk(t1), .din(4'd0), .count(q2), .term(t2)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a negedge: drive inputs, check term and stability, then
    // check the count at the following negedge.
    task automatic step(input logic c, input logic l, input logic p,
                        input logic t, input logic [3:0] d, input string req);
        logic [3:0] nxt;
        clr_n = c; load_n = l; en_par = p; en_trk = t; din = d;
        #1;
        check("R7", int'(term), int'((model == 4'hF) && t));
        check("R2", int'(count), int'(model));
        if (!c)           nxt = 4'd0;
        else if (!l)      nxt = d;
        else if (p && t)  nxt = model + 4'd1;
        else              nxt = model;
        @(negedge clk);
        model = nxt;
        check(req, int'(count), int'(model));
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        model = 4'd0;
        // R10: one clear edge from an unknown state.
        clr_n = 1'b0; load_n = 1'b0; din = 4'd9;
        @(negedge clk);
        check("R10", int'(count), 0);

        // R1/R5: count all the way round, including the 15 -> 0 wrap.
        for (int i = 0; i < 18; i++) step(1, 1, 1, 1, 4'd0, "R1");

        // R6: hold with either enable low.
        step(1, 1, 0, 1, 4'd3, "R6");
        step(1, 1, 1, 0, 4'd3, "R6");
        step(1, 1, 0, 0, 4'd3, "R6");

        // R7: term is independent of en_par and load_n.
        step(1, 0, 0, 0, 4'hF, "R4");
        step(1, 1, 0, 1, 4'd0, "R7");
        step(1, 0, 1, 1, 4'hF, "R7");

        // R8: every start state x every control combination x two data words.
        for (int s = 0; s < 16; s++)
            for (int k = 0; k < 16; k++)
                for (int dv = 0; dv < 2; dv++) begin
                    step(1, 0, 0, 0, 4'(s), "R4");
                    step(k[3], k[2], k[1], k[0], dv ? 4'hA : 4'h5,
                         !k[3] ? "R3" : !k[2] ? "R4" : (k[1] && k[0]) ? "R5" : "R8");
                end

        // R9: 12-bit carry-lookahead chain.
        c_clr_n = 1'b0;
        @(negedge clk);
        c_clr_n = 1'b1;
        check("R9", int'({q2, q1, q0}), 0);
        for (int n = 1; n <= 4100; n++) begin
            @(negedge clk);
            check("R9", int'({q2, q1, q0}), n % 4096);
            if ((n % 4096) == 4095) check("R9", int'(t2), 1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule